// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides, for every received Ethernet frame, whether the frame should be kept or dropped. It watches the first six bytes of the frame on a byte-stream input, which form the 48-bit destination address, compares them with a locally held station address, and applies one of four accept policies. As soon as the sixth destination byte has been taken, it pulses either `accept` or `reject` for exactly one cycle.

A host loads the station address one byte at a time through a small write port. Each of the six address bytes has its own register index. A separate write strobe loads the 2-bit accept policy. The policy and the address are copied into a per-frame snapshot at the start-of-frame strobe. A host can therefore reprogram the filter while a frame is arriving without disturbing the verdict on that frame.

Top module: `rxf_dst_filter`

## Requirements
- R1: After reset, `accept` and `reject` are low, the policy is 0 (accept nothing) and every station byte is 0x00.
- R2: A write with `cfg_we` high and `cfg_idx` = k (0..5) loads `cfg_wdata` into station byte k. Station byte k is compared with the k-th destination byte to arrive, so byte 0 is the first byte on the wire. Writes with `cfg_idx` 6 or 7 change nothing.
- R3: Policy 0 rejects every frame.
- R4: Policy 1 accepts a frame only when all six destination bytes equal the station bytes. A difference in any single byte rejects the frame.
- R5: Policy 2 accepts a station-address match, and also accepts a broadcast destination, which is all six bytes equal to 0xFF. It rejects any other destination.
- R6: Policy 3 accepts every frame.
- R7: The verdict appears in the cycle after the clock edge that takes the sixth destination byte. It lasts one cycle. Exactly one of `accept` and `reject` is high in that cycle, and neither is high at any other time.
- R8: Bytes after the sixth, and bytes arriving while no frame is open, are ignored and produce no further verdict until the next `sof`. A `sof` in mid-address abandons the partial frame without a verdict, and the count restarts.
- R9: Policy and station address are sampled at `sof`. Writes made later in the frame affect only the next frame. A write made in the same cycle as `sof` is not seen by that frame.
- R10: Cycles with `byte_valid` low are not counted, so gaps between destination bytes do not change the verdict. A byte presented in the `sof` cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Station byte write strobe |
| cfg_idx | input | 3 | Station byte index (0..5 valid) |
| cfg_wdata | input | 8 | Station byte value |
| cfg_mode_we | input | 1 | Policy write strobe |
| cfg_mode | input | 2 | Policy: 0 none, 1 station, 2 station or broadcast, 3 all |
| sof | input | 1 | Start-of-frame strobe |
| byte_valid | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| accept | output | 1 | One-cycle keep pulse |
| reject | output | 1 | One-cycle drop pulse |

## Verification
The checker assumes that `sof` marks every frame boundary. It also assumes that the byte stream never produces a verdict without a preceding `sof`. Its policy checks rely on its own copy of the policy, built only from `cfg_mode_we` and `cfg_mode` writes, which follows the same rule of sampling at `sof`. The bench drives every input on the falling clock edge and never asserts `sof` during reset. It counts each frame's verdict from its own model of the station bytes. The sweep covers all four policies against an exact match, broadcast, all zeros, and a single-byte mismatch at each of the six positions.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int OCTET_W    = 8;
    localparam int MAC_OCTETS = 6;

    typedef enum logic [1:0] {
        ACC_NONE      = 2'd0,
        ACC_STATION   = 2'd1,
        ACC_STA_BCAST = 2'd2,
        ACC_ALL       = 2'd3
    } acc_mode_e;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_ADDR = 1'b1
    } frame_state_e;

    typedef struct packed {
        logic      done;
        logic      sta_hit;
        logic      bc_hit;
        acc_mode_e mode;
    } verdict_t;

    function automatic logic take_frame(acc_mode_e m, logic sta, logic bc);
        logic r;
        case (m)
            ACC_NONE:      r = 1'b0;
            ACC_STATION:   r = sta;
            ACC_STA_BCAST: r = sta | bc;
            default:       r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rxf_station_regs.sv
module rxf_station_regs
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = MAC_OCTETS,
    parameter int BYTE_W     = OCTET_W,
    parameter int IDX_W      = 3
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                cfg_we,
    input  logic [IDX_W-1:0]                    cfg_idx,
    input  logic [BYTE_W-1:0]                   cfg_wdata,
    input  logic                                cfg_mode_we,
    input  logic [1:0]                          cfg_mode,
    output logic [ADDR_BYTES-1:0][BYTE_W-1:0]   station_o,
    output acc_mode_e                           mode_o
);

    // One register per address byte; indices past the last byte match none.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                station_o[g] <= '0;
            end else if (cfg_we && (cfg_idx == IDX_W'(g))) begin
                station_o[g] <= cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o <= ACC_NONE;
        end else if (cfg_mode_we) begin
            mode_o <= acc_mode_e'(cfg_mode);
        end
    end

endmodule

// File: rtl/rxf_dst_matcher.sv
module rxf_dst_matcher
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = MAC_OCTETS,
    parameter int BYTE_W     = OCTET_W
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                sof,
    input  logic                                byte_valid,
    input  logic [BYTE_W-1:0]                   byte_data,
    input  logic [ADDR_BYTES-1:0][BYTE_W-1:0]   station_i,
    input  acc_mode_e                           mode_i,
    output verdict_t                            verdict_o
);

    localparam int CNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    frame_state_e                       state_q;
    logic [CNT_W-1:0]                   cnt_q;
    logic [ADDR_BYTES-1:0][BYTE_W-1:0]  snap_q;
    logic                               sta_run_q;
    logic                               bc_run_q;
    logic                               done_q;
    acc_mode_e                          mode_q;

    logic byte_eq;
    logic byte_ff;
    logic take_byte;

    assign byte_eq   = (byte_data == snap_q[cnt_q]);
    assign byte_ff   = &byte_data;
    assign take_byte = (state_q == FS_ADDR) && byte_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= FS_IDLE;
            cnt_q     <= '0;
            snap_q    <= '0;
            sta_run_q <= 1'b0;
            bc_run_q  <= 1'b0;
            done_q    <= 1'b0;
            mode_q    <= ACC_NONE;
        end else begin
            done_q <= 1'b0;
            if (sof) begin
                state_q   <= FS_ADDR;
                cnt_q     <= '0;
                snap_q    <= station_i;
                mode_q    <= mode_i;
                sta_run_q <= 1'b1;
                bc_run_q  <= 1'b1;
            end else if (take_byte) begin
                sta_run_q <= sta_run_q & byte_eq;
                bc_run_q  <= bc_run_q & byte_ff;
                if (cnt_q == LAST_IDX) begin
                    state_q <= FS_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign verdict_o = '{done: done_q, sta_hit: sta_run_q, bc_hit: bc_run_q, mode: mode_q};

endmodule

// File: rtl/rxf_policy.sv
module rxf_policy
    import rxf_pkg::*;
(
    input  verdict_t verdict_i,
    output logic     accept_o,
    output logic     reject_o
);

    logic take;

    assign take     = take_frame(verdict_i.mode, verdict_i.sta_hit, verdict_i.bc_hit);
    assign accept_o = verdict_i.done & take;
    assign reject_o = verdict_i.done & ~take;

endmodule

// File: rtl/rxf_dst_filter.sv
module rxf_dst_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = MAC_OCTETS,
    parameter int BYTE_W     = OCTET_W,
    parameter int IDX_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              cfg_mode_we,
    input  logic [1:0]        cfg_mode,
    input  logic              sof,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              accept,
    output logic              reject
);

    logic [ADDR_BYTES-1:0][BYTE_W-1:0] station;
    acc_mode_e                         mode_live;
    verdict_t                          verdict;

    rxf_station_regs #(
        .ADDR_BYTES (ADDR_BYTES),
        .BYTE_W     (BYTE_W),
        .IDX_W      (IDX_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_idx     (cfg_idx),
        .cfg_wdata   (cfg_wdata),
        .cfg_mode_we (cfg_mode_we),
        .cfg_mode    (cfg_mode),
        .station_o   (station),
        .mode_o      (mode_live)
    );

    rxf_dst_matcher #(
        .ADDR_BYTES (ADDR_BYTES),
        .BYTE_W     (BYTE_W)
    ) u_match (
        .clk        (clk),
        .rst        (rst),
        .sof        (sof),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .station_i  (station),
        .mode_i     (mode_live),
        .verdict_o  (verdict)
    );

    rxf_policy u_policy (
        .verdict_i (verdict),
        .accept_o  (accept),
        .reject_o  (reject)
    );

endmodule

// File: rtl/rxf_dst_filter_chk.sv
module rxf_dst_filter_chk (
    input logic       clk,
    input logic       rst,
    input logic       sof,
    input logic       byte_valid,
    input logic       cfg_mode_we,
    input logic [1:0] cfg_mode,
    input logic       accept,
    input logic       reject
);

    logic       open_q;
    logic [1:0] pol_q;
    logic [1:0] pol_frame_q;
    logic       decided;

    assign decided = accept | reject;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q      <= 1'b0;
            pol_q       <= 2'd0;
            pol_frame_q <= 2'd0;
        end else begin
            if (cfg_mode_we) pol_q <= cfg_mode;
            if (sof) begin
                open_q      <= 1'b1;
                pol_frame_q <= pol_q;
            end else if (decided) begin
                open_q <= 1'b0;
            end
        end
    end

    // R7
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        !(accept && reject));

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        decided |=> !(accept || reject));

    // R8
    decide_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        decided |-> open_q);

    // R10
    decide_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
        decided |-> $past(byte_valid && !sof));

    // R3
    mode_off_chk: assert property (@(posedge clk) disable iff (rst)
        (decided && pol_frame_q == 2'd0) |-> reject);

    // R6
    mode_all_chk: assert property (@(posedge clk) disable iff (rst)
        (decided && pol_frame_q == 2'd3) |-> accept);

endmodule

bind rxf_dst_filter rxf_dst_filter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sof         (sof),
    .byte_valid  (byte_valid),
    .cfg_mode_we (cfg_mode_we),
    .cfg_mode    (cfg_mode),
    .accept      (accept),
    .reject      (reject)
);

// File: tb/rxf_dst_filter_bench.sv
`timescale 1ns/1ps
module rxf_dst_filter_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [2:0] cfg_idx;
    logic [7:0] cfg_wdata;
    logic       cfg_mode_we;
    logic [1:0] cfg_mode;
    logic       sof;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       accept;
    logic       reject;

    int tests = 0;
    int fails = 0;

    logic [7:0] sta_m [6];

    always #2 clk = ~clk;

    rxf_dst_filter u_rxf_dst_filter (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_mode_we(cfg_mode_we), .cfg_mode(cfg_mode),
        .sof(sof), .byte_valid(byte_valid), .byte_data(byte_data),
        .accept(accept), .reject(reject)
    );

    task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {accept,reject} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr_byte(int idx, logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx < 6) sta_m[idx] = v;
    endtask

    task automatic wr_mode(logic [1:0] m);
        @(negedge clk);
        cfg_mode_we = 1'b1; cfg_mode = m;
        @(negedge clk);
        cfg_mode_we = 1'b0;
    endtask

    function automatic logic [1:0] expect_v(logic [1:0] m, logic [7:0] d [6]);
        logic sta = 1'b1;
        logic bc  = 1'b1;
        logic t;
        for (int i = 0; i < 6; i++) begin
            if (d[i] != sta_m[i]) sta = 1'b0;
            if (d[i] != 8'hFF)    bc  = 1'b0;
        end
        case (m)
            2'd0: t = 1'b0;
            2'd1: t = sta;
            2'd2: t = sta | bc;
            default: t = 1'b1;
        endcase
        return {t, ~t};
    endfunction

    // Opens a frame, sends six bytes (with a gap after each when gap=1),
    // then checks the pulse and the quiet cycle after it.
    task automatic frame(string req, logic [7:0] d [6], logic [1:0] exp, bit gap);
        @(negedge clk);
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        for (int i = 0; i < 6; i++) begin
            byte_valid = 1'b1; byte_data = d[i];
            @(negedge clk);
            byte_valid = 1'b0;
            if (i < 5) begin
                chk(req, {accept, reject}, 2'b00);
                if (gap) @(negedge clk);
            end
        end
        chk(req, {accept, reject}, exp);
        @(negedge clk);
        chk(req, {accept, reject}, 2'b00);
    endtask

    initial begin
        #(4ns * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d [6];
        rst = 1'b1; cfg_we = 0; cfg_idx = 0; cfg_wdata = 0;
        cfg_mode_we = 0; cfg_mode = 0; sof = 0; byte_valid = 0; byte_data = 0;
        for (int i = 0; i < 6; i++) sta_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs idle after reset
        chk("R1", {accept, reject}, 2'b00);
        // R1: reset policy is none, so an all-zero destination is rejected
        for (int i = 0; i < 6; i++) d[i] = 8'h00;
        frame("R1", d, 2'b01, 0);
        // R1: reset station is zero: policy 1 accepts all-zero destination
        wr_mode(2'd1);
        frame("R1", d, 2'b10, 0);

        // R2: load station bytes, byte 0 first on the wire
        wr_byte(0, 8'h02); wr_byte(1, 8'h1A); wr_byte(2, 8'h2B);
        wr_byte(3, 8'h3C); wr_byte(4, 8'h4D); wr_byte(5, 8'h5E);
        // R2: out-of-range indices change nothing
        wr_byte(6, 8'h99); wr_byte(7, 8'h77);
        for (int i = 0; i < 6; i++) d[i] = sta_m[i];
        frame("R2", d, 2'b10, 0);
        // R2: byte-reversed destination does not match
        for (int i = 0; i < 6; i++) d[i] = sta_m[5 - i];
        frame("R2", d, 2'b01, 0);

        // R3 R4 R5 R6: sweep policies over destination patterns
        for (int m = 0; m < 4; m++) begin
            wr_mode(2'(m));
            for (int p = 0; p < 9; p++) begin
                for (int i = 0; i < 6; i++) begin
                    case (p)
                        0: d[i] = sta_m[i];
                        1: d[i] = 8'hFF;
                        2: d[i] = 8'h00;
                        default: d[i] = (i == p - 3) ? (sta_m[i] ^ 8'h01) : sta_m[i];
                    endcase
                end
                case (m)
                    0: frame("R3", d, expect_v(2'(m), d), p[0]);
                    1: frame("R4", d, expect_v(2'(m), d), p[0]);
                    2: frame("R5", d, expect_v(2'(m), d), p[0]);
                    default: frame("R6", d, expect_v(2'(m), d), p[0]);
                endcase
            end
        end
        // R5: five 0xFF bytes and one 0xFE is not broadcast
        wr_mode(2'd2);
        for (int i = 0; i < 6; i++) d[i] = (i == 5) ? 8'hFE : 8'hFF;
        frame("R5", d, 2'b01, 0);

        // R8: extra bytes after the sixth and bytes with no frame open
        wr_mode(2'd3);
        for (int i = 0; i < 6; i++) d[i] = 8'h10;
        frame("R8", d, 2'b10, 0);
        for (int k = 0; k < 8; k++) begin
            byte_valid = 1'b1; byte_data = 8'(k);
            @(negedge clk);
            chk("R8", {accept, reject}, 2'b00);
        end
        byte_valid = 1'b0;
        // R8: sof in mid-address abandons the partial frame
        @(negedge clk); sof = 1'b1;
        @(negedge clk); sof = 1'b0;
        for (int k = 0; k < 3; k++) begin
            byte_valid = 1'b1; byte_data = 8'h33;
            @(negedge clk);
        end
        byte_valid = 1'b0;
        chk("R8", {accept, reject}, 2'b00);
        frame("R8", d, 2'b10, 0);

        // R9: mid-frame config change does not affect the open frame
        wr_mode(2'd1);
        for (int i = 0; i < 6; i++) d[i] = sta_m[i];
        @(negedge clk); sof = 1'b1;
        @(negedge clk); sof = 1'b0;
        cfg_mode_we = 1'b1; cfg_mode = 2'd0;
        cfg_we = 1'b1; cfg_idx = 3'd5; cfg_wdata = 8'hA5;
        for (int i = 0; i < 6; i++) begin
            byte_valid = 1'b1; byte_data = d[i];
            @(negedge clk);
            cfg_mode_we = 1'b0; cfg_we = 1'b0;
        end
        byte_valid = 1'b0;
        chk("R9", {accept, reject}, 2'b10);
        sta_m[5] = 8'hA5;
        // R9: next frame sees policy 0
        frame("R9", d, 2'b01, 0);
        // R9: write in the sof cycle is not seen by that frame
        @(negedge clk); sof = 1'b1; cfg_mode_we = 1'b1; cfg_mode = 2'd3;
        @(negedge clk); sof = 1'b0; cfg_mode_we = 1'b0;
        for (int i = 0; i < 6; i++) begin
            byte_valid = 1'b1; byte_data = d[i];
            @(negedge clk);
        end
        byte_valid = 1'b0;
        chk("R9", {accept, reject}, 2'b01);
        frame("R9", d, 2'b10, 0);

        // R10: byte presented in the sof cycle is not counted
        wr_mode(2'd1);
        for (int i = 0; i < 6; i++) d[i] = sta_m[i];
        @(negedge clk); sof = 1'b1; byte_valid = 1'b1; byte_data = 8'hEE;
        @(negedge clk); sof = 1'b0;
        for (int i = 0; i < 6; i++) begin
            byte_valid = 1'b1; byte_data = d[i];
            @(negedge clk);
        end
        byte_valid = 1'b0;
        chk("R10", {accept, reject}, 2'b10);
        // R7: exactly one pulse, then quiet
        @(negedge clk);
        chk("R7", {accept, reject}, 2'b00);
        // R10: gaps between bytes
        frame("R10", d, 2'b10, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule